// File: doc/BRIEF.md
# Sleep Entry and Watchdog Status Controller

This block sits beside the decoder of a small 8-bit processor core and carries out the sleep instruction. It follows the four phases of each instruction cycle. It recognises the sleep opcode in the decode phase and puts the core to sleep at the last phase of the same cycle. On entry it drops the oscillator enable, clears the watchdog counter and its postscaler, and updates the power-down (`pd_o`) and time-out (`to_o`) status bits.

The block runs on an always-on clock, so the watchdog keeps counting while the core clock is stopped. The core is woken either by a watchdog time-out or by an interrupt wake request. On a time-out wake, `to_o` is cleared to record the cause. On an interrupt wake, both status bits are left as they are. A wake raises the oscillator enable again and gives a one-cycle `wake_o` pulse that tells the core to resume fetching.

Top module: `sleep_wdt_ctrl`

## Requirements
- R1: After reset `pd_o`=1, `to_o`=1, `osc_en_o`=1, `wake_o`=0, and `wdt_cnt_o` and `wdt_post_o` are both 0.
- R2: Only the exact word 16'h0003 can start sleep. It must be presented with `instr_valid_i`=1 on the phase tick that ends decode phase Q1 (phase index 0). Any other word, an invalid word, or the opcode at another phase has no effect on `osc_en_o`.
- R3: The phase index advances by one on each `phase_tick_i` while running and wraps from 3 to 0. After the tick that ends Q4 (phase index 3) of a decoded sleep cycle, `osc_en_o` reads 0. The earlier phase ticks leave it at 1.
- R4: Sleep entry sets `pd_o`=0 and `to_o`=1.
- R5: Sleep entry resets `wdt_cnt_o` and `wdt_post_o` to 0. This takes priority over counting and over a time-out in the same cycle.
- R6: While `wdt_en_i`=1, `wdt_cnt_o` increments once per clock, whether the core is running or asleep. `wdt_post_o` increments on the clock where `wdt_cnt_o` wraps from all ones. When both fields are all ones, the next enabled clock is a time-out and both wrap to 0. While `wdt_en_i`=0, both fields hold.
- R7: A time-out during sleep wakes the core, clears `to_o` to 0 and leaves `pd_o` at 0.
- R8: An `irq_wake_i` during sleep, with no time-out in that cycle, wakes the core and leaves `to_o` and `pd_o` unchanged.
- R9: A wake sets `osc_en_o`=1 and `wake_o`=1 for exactly one clock. If a time-out and an interrupt arrive in the same cycle, the time-out outcome (`to_o`=0) wins.
- R10: While running, a time-out clears `to_o` and leaves `pd_o` unchanged. `irq_wake_i` is ignored and `wake_o` stays 0.
- R11: While asleep, `phase_tick_i` and the instruction inputs are ignored. The phase index is held at 0, so the core resumes at Q1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| instr_i | input | 16 | Instruction word from the fetch stage |
| instr_valid_i | input | 1 | Instruction word is valid |
| phase_tick_i | input | 1 | End of one instruction-cycle phase |
| wdt_en_i | input | 1 | Watchdog enable |
| irq_wake_i | input | 1 | Enabled interrupt wake request |
| osc_en_o | output | 1 | Oscillator enable, 0 while asleep |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| wake_o | output | 1 | One-cycle resume pulse |
| wdt_cnt_o | output | CNT_W | Watchdog counter |
| wdt_post_o | output | POST_W | Watchdog postscaler |

## Verification
The bench builds the block with `CNT_W`=3 and `POST_W`=2. With these values a time-out comes after 32 enabled clocks. That makes several things reachable in short runs:
- time-outs in both the running and the sleeping state,
- a time-out landing in the same cycle as an interrupt wake,
- a time-out landing in the same cycle as a sleep entry.

Counter wrap and postscaler carry are crossed many times in each random stretch, and a stretch with the watchdog disabled shows that only an interrupt can end sleep.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  localparam logic [15:0] SLEEP_OP = 16'h0003;
  localparam logic [1:0]  PH_DECODE = 2'd0;
  localparam logic [1:0]  PH_ENTER  = 2'd3;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/sleep_decode.sv
module sleep_decode
  import sleep_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        tick_i,
  input  logic        instr_valid_i,
  input  logic [15:0] instr_i,
  output logic        enter_o
);
  logic [1:0] ph_q;
  logic       pend_q;

  assign enter_o = run_i && tick_i && (ph_q == PH_ENTER) && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_DECODE;
      pend_q <= 1'b0;
    end else if (!run_i) begin
      // core clock stopped: resume at decode
      ph_q   <= PH_DECODE;
      pend_q <= 1'b0;
    end else if (tick_i) begin
      ph_q <= ph_q + 2'd1;
      if (ph_q == PH_DECODE)
        pend_q <= instr_valid_i && (instr_i == SLEEP_OP);
      else if (ph_q == PH_ENTER)
        pend_q <= 1'b0;
    end
  end

  p_enter_stops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> !run_i);

  p_asleep_resume_q1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (ph_q == PH_DECODE) && !enter_o);
endmodule

// File: rtl/sleep_wdt.sv
module sleep_wdt #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [POST_W-1:0] post_o,
  output logic              tmo_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [POST_W-1:0] POST_MAX = {POST_W{1'b1}};

  logic [CNT_W-1:0]  cnt_q;
  logic [POST_W-1:0] post_q;

  assign cnt_o  = cnt_q;
  assign post_o = post_q;
  // clear wins over a coincident time-out
  assign tmo_o  = en_i && !clr_i && (cnt_q == CNT_MAX) && (post_q == POST_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      post_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      post_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_MAX) post_q <= post_q + POST_W'(1);
    end
  end

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0) && (post_o == '0));

  p_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1))));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(cnt_o) && $stable(post_o)));
endmodule

// File: rtl/sleep_wdt_ctrl.sv
module sleep_wdt_ctrl
  import sleep_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       instr_i,
  input  logic              instr_valid_i,
  input  logic              phase_tick_i,
  input  logic              wdt_en_i,
  input  logic              irq_wake_i,
  output logic              osc_en_o,
  output logic              pd_o,
  output logic              to_o,
  output logic              wake_o,
  output logic [CNT_W-1:0]  wdt_cnt_o,
  output logic [POST_W-1:0] wdt_post_o
);
  pwr_state_e state_q;
  logic pd_q, to_q, wake_q;
  logic enter, tmo, run;

  assign run      = (state_q == ST_RUN);
  assign osc_en_o = run;
  assign pd_o     = pd_q;
  assign to_o     = to_q;
  assign wake_o   = wake_q;

  sleep_decode u_decode (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .tick_i        (phase_tick_i),
    .instr_valid_i (instr_valid_i),
    .instr_i       (instr_i),
    .enter_o       (enter)
  );

  sleep_wdt #(.CNT_W(CNT_W), .POST_W(POST_W)) u_wdt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wdt_en_i),
    .clr_i  (enter),
    .cnt_o  (wdt_cnt_o),
    .post_o (wdt_post_o),
    .tmo_o  (tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pd_q    <= 1'b1;
      to_q    <= 1'b1;
      wake_q  <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      if (enter) begin
        state_q <= ST_SLEEP;
        pd_q    <= 1'b0;
        to_q    <= 1'b1;
      end else if (!run) begin
        if (tmo) begin
          state_q <= ST_RUN;
          to_q    <= 1'b0;
          wake_q  <= 1'b1;
        end else if (irq_wake_i) begin
          state_q <= ST_RUN;
          wake_q  <= 1'b1;
        end
      end else if (tmo) begin
        to_q <= 1'b0;
      end
    end
  end

  p_entry_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> (!pd_o && to_o && !osc_en_o));

  p_tmo_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && tmo) |=> (!to_o && !pd_o && osc_en_o));

  p_irq_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !tmo && irq_wake_i) |=> ($stable(to_o) && $stable(pd_o) && osc_en_o));

  p_wake_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  p_run_tmo_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tmo && !enter) |=> (!to_o && $stable(pd_o) && !wake_o));
endmodule

// File: tb/sleep_wdt_ctrl_tb.sv
module sleep_wdt_ctrl_tb;
  localparam int CW = 3;
  localparam int PW = 2;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [PW-1:0] PMAX = {PW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic instr_valid = 1'b0, tick = 1'b0, wdt_en = 1'b0, irq = 1'b0;
  logic osc_en, pd, to, wake;
  logic [CW-1:0] cnt;
  logic [PW-1:0] post;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sleep_wdt_ctrl #(.CNT_W(CW), .POST_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(instr_valid),
    .phase_tick_i(tick), .wdt_en_i(wdt_en), .irq_wake_i(irq),
    .osc_en_o(osc_en), .pd_o(pd), .to_o(to), .wake_o(wake),
    .wdt_cnt_o(cnt), .wdt_post_o(post)
  );

  // reference model written from the requirements
  logic m_run, m_pd, m_to, m_wake, m_pend;
  logic [1:0] m_ph;
  logic [CW-1:0] m_cnt;
  logic [PW-1:0] m_post;

  function automatic logic is_tmo(logic en, logic [CW-1:0] c, logic [PW-1:0] p);
    return en && (c == CMAX) && (p == PMAX);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 1; m_pd = 1; m_to = 1; m_wake = 0; m_pend = 0; m_ph = 0; m_cnt = 0; m_post = 0;
    end else begin
      logic ent, tm;
      ent = m_run && tick && (m_ph == 2'd3) && m_pend;
      tm  = is_tmo(wdt_en, m_cnt, m_post) && !ent;
      m_wake = 0;
      if (ent) begin
        m_cnt = 0; m_post = 0;
      end else if (wdt_en) begin
        if (m_cnt == CMAX) m_post = m_post + 1'b1;
        m_cnt = m_cnt + 1'b1;
      end
      if (!m_run) begin
        m_ph = 0; m_pend = 0;
      end else if (tick) begin
        if (m_ph == 2'd0) m_pend = instr_valid && (instr == 16'h0003);
        else if (m_ph == 2'd3) m_pend = 0;
        m_ph = m_ph + 2'd1;
      end
      if (ent) begin
        m_run = 0; m_pd = 0; m_to = 1; m_ph = 0; m_pend = 0;
      end else if (!m_run) begin
        if (tm) begin m_run = 1; m_to = 0; m_wake = 1; end
        else if (irq) begin m_run = 1; m_wake = 1; end
      end else if (tm) m_to = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R3 osc_en", osc_en, m_run);
    chk("R4 pd", pd, m_pd);
    chk("R7 to", to, m_to);
    chk("R9 wake", wake, m_wake);
    chk("R6 cnt", cnt, m_cnt);
    chk("R6 post", post, m_post);
  endtask

  task automatic step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drive(input logic t, input logic v, input logic [15:0] w,
                       input logic e, input logic q);
    tick = t; instr_valid = v; instr = w; wdt_en = e; irq = q;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pd", pd, 1); chk("R1 to", to, 1); chk("R1 osc_en", osc_en, 1);
    chk("R1 wake", wake, 0); chk("R1 cnt", cnt, 0); chk("R1 post", post, 0);

    // count while running, then sleep entry clears it
    drive(0, 0, 0, 1, 0); steps(5);
    chk("R6 cnt after 5", cnt, 5);
    drive(1, 1, 16'h0003, 1, 0); step();
    drive(1, 0, 16'h0003, 1, 0); steps(2);
    chk("R3 still running before Q4", osc_en, 1);
    step();
    chk("R3 asleep after Q4", osc_en, 0);
    chk("R4 pd", pd, 0); chk("R4 to", to, 1);
    chk("R5 cnt", cnt, 0); chk("R5 post", post, 0);

    // disabled watchdog, ticks ignored while asleep
    drive(1, 1, 16'h0003, 0, 0); steps(10);
    chk("R11 still asleep", osc_en, 0);
    chk("R6 hold cnt", cnt, 0);
    drive(0, 0, 0, 0, 1); step();
    chk("R8 osc_en", osc_en, 1); chk("R8 wake", wake, 1);
    chk("R8 to", to, 1); chk("R8 pd", pd, 0);
    drive(0, 0, 0, 0, 0); step();
    chk("R9 wake one cycle", wake, 0);

    // time-out while running, irq ignored
    drive(0, 0, 0, 1, 1); steps(31);
    chk("R10 to before tmo", to, 1);
    step();
    chk("R10 to after tmo", to, 0); chk("R10 pd", pd, 0);
    chk("R10 wake", wake, 0); chk("R10 osc_en", osc_en, 1);

    // decode filtering
    drive(1, 1, 16'h0013, 1, 0); step();
    drive(1, 0, 0, 1, 0); steps(3);
    chk("R2 wrong word", osc_en, 1);
    drive(1, 0, 16'h0003, 1, 0); step();
    drive(1, 0, 0, 1, 0); steps(3);
    chk("R2 invalid word", osc_en, 1);
    drive(1, 1, 16'h0000, 1, 0); step();
    drive(1, 1, 16'h0003, 1, 0); step();
    drive(1, 0, 0, 1, 0); steps(2);
    chk("R2 opcode at Q2", osc_en, 1);

    // real sleep, then time-out and irq in the same cycle
    drive(1, 1, 16'h0003, 1, 0); step();
    drive(1, 0, 0, 1, 0); steps(3);
    chk("R4 asleep", osc_en, 0); chk("R4 to", to, 1);
    drive(0, 0, 0, 1, 0); steps(31);
    chk("R7 still asleep", osc_en, 0);
    drive(0, 0, 0, 1, 1); step();
    chk("R9 awake", osc_en, 1); chk("R9 to priority", to, 0);
    chk("R7 pd", pd, 0); chk("R9 wake", wake, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] w;
      w = ($urandom % 3 == 0) ? 16'h0003 : 16'($urandom);
      drive(1'($urandom % 2), 1'($urandom % 4 != 0), w,
            1'($urandom % 8 != 0), 1'($urandom % 40 == 0));
      step();
    end

    summary();
    $finish;
  end
endmodule